// File: doc/BRIEF.md
# Dual-Edge Adaptive Synchronous Rectifier Gate Driver

This block makes the two synchronous-rectifier (SR) gate commands of a half-bridge resonant converter. It runs on a 40 MHz clock. For each phase it takes the primary gate drive of that phase and a flag from a comparator that shows the SR of that phase is conducting. A phase cycle starts at the rising edge of its primary gate. During the cycle the block counts how many clock periods the SR conducted. It also counts how many periods conduction lasted after the primary gate went low.

In the next cycle of the same phase it builds two predicted windows from those counts. Window one reproduces the last conduction length, measured from the primary rising edge. Window two is the live primary pulse, stretched by the last extension count. The SR gate is the AND of the two windows, with a turn-on and turn-off margin (dead time) applied.

Three conditions hold both gates low. The first is a light-load flag, which widens the dead time. The second is a very-light-load flag, which disables SR drive until a separate resume flag arrives. The third is PWM operation of the controller.

Top module: `sr_dual_edge_drv`

## Requirements
- R1: Let Lc be the number of clock periods the conduction flag was sampled high in the previous cycle of a phase, counted over the first contiguous high interval starting at or after the primary rising edge. Let k be the period index in the current cycle, with k = 1 in the first period after the edge that samples the primary high. Window one is open while k + dt <= Lc.
- R2: The extension count Le is the number of periods in that first interval in which the conduction flag was high while the primary gate was sampled low. If conduction ends while the primary is still high, Le is 0.
- R3: Let P be the current primary pulse length. If Le = 0, window two is exactly the periods in which the primary is high. Otherwise window two is open while k <= P + Le - dt.
- R4: A phase gate is high exactly in the periods with k > dt in which both windows are open. As a result the pulse width equals min(Lc - dt, window-two end) - dt, or 0 if that value is not positive.
- R5: The dead time dt equals dt_cfg while lite_load is low, and dt_cfg + SHRINK_ADD (default 4) while it is high. The widening acts on both edges, and the programmed value returns as soon as the flag clears.
- R6: From the first edge that samples vlite_off high, both gates are low in every following period. They stay off until sr_resume is sampled high while vlite_off is low. If both flags are high in the same period, the drive stays off.
- R7: While pwm_mode is high, both gates are low in the same period. The measurements keep running, so the first cycle after pwm_mode clears uses the counts taken during PWM operation.
- R8: All counters are 10 bits (CNT_W) and saturate at 1023 instead of wrapping. A cycle with no detected conduction gives Lc = 0, so the next cycle of that phase has no pulse.
- R9: After reset or re-enable, a phase gate stays low through the first primary cycle of that phase. Drive can start in the second cycle.
- R10: The two gates are never high in the same period. When both phases request drive, both gates are low.
- R11: During and right after reset both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_gate_a | input | 1 | Primary gate drive, phase A |
| pri_gate_b | input | 1 | Primary gate drive, phase B |
| cond_a | input | 1 | SR conduction-detect flag, phase A |
| cond_b | input | 1 | SR conduction-detect flag, phase B |
| pwm_mode | input | 1 | Controller in PWM operation; forces both gates low |
| lite_load | input | 1 | Light-load flag; widens SR dead time |
| vlite_off | input | 1 | Very-light-load flag; disables SR drive |
| sr_resume | input | 1 | Re-enable flag for SR drive |
| dt_cfg | input | DT_W (4) | Programmed SR dead time in clock periods |
| sr_gate_a | output | 1 | SR gate command, phase A |
| sr_gate_b | output | 1 | SR gate command, phase B |

## Verification
The two functions that meet in one cycle are the extended window two of one phase and the start of drive of the other phase. Each is correct on its own, but together they collide, and the block must then hold both gates low.

The test provokes this by first training phase A with a long conduction and extension. It then starts phase B only twelve periods after A's primary edge, while A's predicted window is still open. The judgement is made on the number of high periods each gate shows inside each phase's cycle: phase B must show none, phase A only its periods outside the overlap, and the count of periods with both gates high must stay at zero.

// File: rtl/sr_drv_pkg.sv
`timescale 1ns/1ps
package sr_drv_pkg;

  // Saturating increment: holds at maxv instead of wrapping.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

  // True while position k, moved forward by the margin dt, still lies inside a window of length lim.
  function automatic logic in_window(input int unsigned k, input int unsigned lim,
                                     input int unsigned dt);
    return (k + dt) <= lim;
  endfunction

  // Effective dead time: base plus optional widening, clipped to the counter range.
  function automatic int unsigned dt_effective(input int unsigned base, input logic widen,
                                               input int unsigned add, input int unsigned maxv);
    int unsigned s;
    s = base + (widen ? add : 0);
    return (s > maxv) ? maxv : s;
  endfunction

endpackage

// File: rtl/sr_en_latch.sv
`timescale 1ns/1ps
module sr_en_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic off_req,
  input  logic on_req,
  output logic en
);
  // Disable has priority over resume; SR drive is allowed out of reset.
  always_ff @(posedge clk) begin
    if (!rst_n)       en <= 1'b1;
    else if (off_req) en <= 1'b0;
    else if (on_req)  en <= 1'b1;
  end
endmodule

// File: rtl/sr_dt_sel.sv
`timescale 1ns/1ps
module sr_dt_sel #(
  parameter int CNT_W      = 10,
  parameter int DT_W       = 4,
  parameter int SHRINK_ADD = 4
) (
  input  logic [DT_W-1:0]  dt_cfg,
  input  logic             widen,
  output logic [CNT_W-1:0] dt
);
  import sr_drv_pkg::*;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  assign dt = cnt_t'(dt_effective(int'(dt_cfg), widen, SHRINK_ADD, CMAX));
endmodule

// File: rtl/sr_phase_trk.sv
`timescale 1ns/1ps
module sr_phase_trk #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             pri,
  input  logic             cond,
  input  logic [CNT_W-1:0] dt,
  output logic             want,
  output logic             win1,
  output logic             win2,
  output logic             valid,
  output logic             rise_evt,
  output logic [CNT_W-1:0] cnd_run_o
);
  import sr_drv_pkg::*;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  logic pri_d;
  cnt_t el;        // periods since primary rise
  cnt_t fe;        // periods since primary fall, 0 while primary high
  cnt_t cnd_run;   // conduction periods this cycle
  cnt_t ext_run;   // conduction periods after primary fall this cycle
  cnt_t last_cnd;
  cnt_t last_ext;
  logic cnd_done;
  logic armed;
  logic vld;
  logic fall_evt;
  logic cnt_now;

  assign rise_evt = pri & ~pri_d;
  assign fall_evt = ~pri & pri_d;
  assign cnt_now  = cond & ~cnd_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_d    <= 1'b0;
      el       <= '0;
      fe       <= '0;
      cnd_run  <= '0;
      ext_run  <= '0;
      last_cnd <= '0;
      last_ext <= '0;
      cnd_done <= 1'b0;
    end else begin
      pri_d <= pri;
      if (rise_evt) begin
        last_cnd <= cnd_run;
        last_ext <= ext_run;
        cnd_run  <= cnt_t'(cond);
        ext_run  <= '0;
        cnd_done <= 1'b0;
        el       <= cnt_t'(1);
        fe       <= '0;
      end else begin
        el <= cnt_t'(sat_inc(int'(el), CMAX));
        if (cnt_now)        cnd_run <= cnt_t'(sat_inc(int'(cnd_run), CMAX));
        if (cnt_now && !pri) ext_run <= cnt_t'(sat_inc(int'(ext_run), CMAX));
        if (!cond && (cnd_run != '0)) cnd_done <= 1'b1;
        if (fall_evt)        fe <= cnt_t'(1);
        else if (fe != '0)   fe <= cnt_t'(sat_inc(int'(fe), CMAX));
      end
    end
  end

  // One full measured cycle is needed after reset or re-enable.
  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      armed <= 1'b0;
      vld   <= 1'b0;
    end else if (rise_evt) begin
      armed <= 1'b1;
      vld   <= armed;
    end
  end

  assign win1      = in_window(int'(el), int'(last_cnd), int'(dt));
  assign win2      = pri_d | ((fe != '0) & in_window(int'(fe), int'(last_ext), int'(dt)));
  assign want      = vld & (el > dt) & win1 & win2;
  assign valid     = vld;
  assign cnd_run_o = cnd_run;
endmodule

// File: rtl/sr_dual_edge_drv.sv
`timescale 1ns/1ps
module sr_dual_edge_drv #(
  parameter int CNT_W      = 10,
  parameter int DT_W       = 4,
  parameter int SHRINK_ADD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pri_gate_a,
  input  logic            pri_gate_b,
  input  logic            cond_a,
  input  logic            cond_b,
  input  logic            pwm_mode,
  input  logic            lite_load,
  input  logic            vlite_off,
  input  logic            sr_resume,
  input  logic [DT_W-1:0] dt_cfg,
  output logic            sr_gate_a,
  output logic            sr_gate_b
);
  localparam int N_PH = 2;

  logic [N_PH-1:0]  pri_v, cond_v;
  logic [N_PH-1:0]  trk_want, trk_w1, trk_w2, trk_valid, trk_rise, raw_gate;
  logic [CNT_W-1:0] trk_cnd [N_PH];
  logic [CNT_W-1:0] dt_eff;
  logic             sr_en, hold, allow, clash;

  assign pri_v  = {pri_gate_b, pri_gate_a};
  assign cond_v = {cond_b, cond_a};
  assign hold   = ~sr_en;

  sr_en_latch u_en (
    .clk(clk), .rst_n(rst_n), .off_req(vlite_off), .on_req(sr_resume), .en(sr_en)
  );

  sr_dt_sel #(.CNT_W(CNT_W), .DT_W(DT_W), .SHRINK_ADD(SHRINK_ADD)) u_dt (
    .dt_cfg(dt_cfg), .widen(lite_load), .dt(dt_eff)
  );

  generate
    for (genvar i = 0; i < N_PH; i++) begin : g_ph
      sr_phase_trk #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .hold(hold), .pri(pri_v[i]), .cond(cond_v[i]),
        .dt(dt_eff), .want(trk_want[i]), .win1(trk_w1[i]), .win2(trk_w2[i]),
        .valid(trk_valid[i]), .rise_evt(trk_rise[i]), .cnd_run_o(trk_cnd[i])
      );
      assign raw_gate[i] = trk_want[i] & allow;
    end
  endgenerate

  assign allow     = sr_en & ~pwm_mode;
  assign clash     = &raw_gate;
  assign sr_gate_a = raw_gate[0] & ~clash;
  assign sr_gate_b = raw_gate[1] & ~clash;
endmodule

// File: rtl/sr_drv_chk.sv
`timescale 1ns/1ps
module sr_drv_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_mode,
  input logic             off_req,
  input logic             sr_a,
  input logic             sr_b,
  input logic [1:0]       trk_valid,
  input logic [1:0]       trk_w1,
  input logic [1:0]       trk_w2,
  input logic [1:0]       trk_rise,
  input logic [CNT_W-1:0] cnd0,
  input logic [CNT_W-1:0] cnd1
);
  assert_mutex_R10: assert property (@(posedge clk) disable iff (!rst_n) !(sr_a && sr_b));

  assert_pwm_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |-> (!sr_a && !sr_b));

  assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> (!sr_a && !sr_b));

  assert_armed_a_R9: assert property (@(posedge clk) disable iff (!rst_n) sr_a |-> trk_valid[0]);
  assert_armed_b_R9: assert property (@(posedge clk) disable iff (!rst_n) sr_b |-> trk_valid[1]);

  assert_and_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_a |-> (trk_w1[0] && trk_w2[0]));
  assert_and_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_b |-> (trk_w1[1] && trk_w2[1]));

  assert_sat_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnd0 == '1) && !trk_rise[0]) |=> (cnd0 == '1));
  assert_sat_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnd1 == '1) && !trk_rise[1]) |=> (cnd1 == '1));
endmodule

bind sr_dual_edge_drv sr_drv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .off_req(vlite_off),
  .sr_a(sr_gate_a), .sr_b(sr_gate_b), .trk_valid(trk_valid), .trk_w1(trk_w1),
  .trk_w2(trk_w2), .trk_rise(trk_rise), .cnd0(trk_cnd[0]), .cnd1(trk_cnd[1])
);

// File: tb/sim_sr_dual_edge_drv.sv
`timescale 1ns/1ps
module sim_sr_dual_edge_drv;
  localparam int CNT_W = 10, DT_W = 4, SHRINK_ADD = 4;

  typedef struct packed {
    int ph; int p; int c; int dt; int shr; int exp; int req;
  } vec_t;

  // phase, primary length, conduction length, dt_cfg, lite_load, expected width, requirement
  localparam vec_t VEC [0:13] = '{
    '{0, 20, 25, 1, 0,  0, 9},  // R9 first cycle A
    '{1, 20, 18, 1, 0,  0, 9},  // R9 first cycle B
    '{0, 20, 25, 1, 0, 23, 1},  // R1 steady, extension 5
    '{1, 20, 18, 1, 0, 16, 2},  // R2 early end -> Le 0
    '{0, 12, 25, 1, 0, 15, 3},  // R3 shorter primary cuts window two
    '{1, 20, 30, 2, 0, 14, 1},  // R1 window one bounds
    '{0, 20, 10, 2, 0, 21, 4},  // R4 AND of windows
    '{1, 15, 30, 0, 0, 25, 3},  // R3 extended primary
    '{0, 20, 10, 0, 1,  2, 5},  // R5 shrink dt 0+4
    '{1, 15, 30, 1, 1, 20, 5},  // R5 shrink dt 1+4 both edges
    '{0, 20,  0, 1, 0,  8, 5},  // R5 back to programmed dt
    '{1, 30, 20, 1, 0, 28, 4},  // R4
    '{0, 20, 20, 1, 0,  0, 8},  // R8 no conduction last cycle
    '{0, 20, 20, 1, 0, 18, 1}   // R1 recovery
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pri_a = 1'b0, pri_b = 1'b0, cond_a = 1'b0, cond_b = 1'b0;
  logic pwm_mode = 1'b0, lite_load = 1'b0, vlite_off = 1'b0, sr_on = 1'b0;
  logic [DT_W-1:0] dt_cfg = '0;
  logic sr_gate_a, sr_gate_b;

  int n_chk = 0, n_bad = 0, hi_a = 0, hi_b = 0, both_hi = 0, cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sr_dual_edge_drv #(.CNT_W(CNT_W), .DT_W(DT_W), .SHRINK_ADD(SHRINK_ADD)) u0 (
    .clk(clk), .rst_n(rst_n), .pri_gate_a(pri_a), .pri_gate_b(pri_b),
    .cond_a(cond_a), .cond_b(cond_b), .pwm_mode(pwm_mode), .lite_load(lite_load),
    .vlite_off(vlite_off), .sr_resume(sr_on), .dt_cfg(dt_cfg),
    .sr_gate_a(sr_gate_a), .sr_gate_b(sr_gate_b)
  );

  // Output monitor, one sample per period, away from the clock edge.
  always begin
    @(negedge clk); #1;
    if (sr_gate_a) hi_a++;
    if (sr_gate_b) hi_b++;
    if (sr_gate_a && sr_gate_b) both_hi++;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      report();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cyc(input int ph, input int p, input int c, input int len,
                         input bit off0, input bit on0, output int wa, output int wb);
    int sa, sb;
    sa = hi_a; sb = hi_b;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      pri_a  = (ph == 0) && (j < p);
      cond_a = (ph == 0) && (j < c);
      pri_b  = (ph == 1) && (j < p);
      cond_b = (ph == 1) && (j < c);
      vlite_off = off0 && (j == 0);
      sr_on     = on0  && (j == 0);
    end
    wa = hi_a - sa;
    wb = hi_b - sb;
  endtask

  task automatic idle(input int n, input bit on0);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      pri_a = 1'b0; pri_b = 1'b0; cond_a = 1'b0; cond_b = 1'b0;
      vlite_off = 1'b0;
      sr_on = on0 && (j == 1);
    end
  endtask

  initial begin
    int wa, wb, own, oth;
    // R11: reset state
    pri_a = 1'b1; cond_a = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R11 gate A in reset", int'(sr_gate_a), 0);
    check("R11 gate B in reset", int'(sr_gate_b), 0);
    @(negedge clk); pri_a = 1'b0; cond_a = 1'b0; rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 gate A after reset", int'(sr_gate_a), 0);
    check("R11 gate B after reset", int'(sr_gate_b), 0);

    // Vector table
    foreach (VEC[i]) begin
      dt_cfg    = DT_W'(VEC[i].dt);
      lite_load = VEC[i].shr != 0;
      run_cyc(VEC[i].ph, VEC[i].p, VEC[i].c, 64, 1'b0, 1'b0, wa, wb);
      own = (VEC[i].ph == 0) ? wa : wb;
      oth = (VEC[i].ph == 0) ? wb : wa;
      check($sformatf("R%0d vector %0d width", VEC[i].req, i), own, VEC[i].exp);
      check($sformatf("R10 vector %0d idle phase", i), oth, 0);
    end
    lite_load = 1'b0;
    dt_cfg = DT_W'(1);

    // R7: PWM mode silences drive, measurement continues
    pwm_mode = 1'b1;
    run_cyc(0, 20, 25, 64, 1'b0, 1'b0, wa, wb);
    check("R7 gate A in PWM mode", wa, 0);
    pwm_mode = 1'b0;
    run_cyc(0, 20, 25, 64, 1'b0, 1'b0, wa, wb);
    check("R7 gate A uses counts from PWM cycle", wa, 23);

    // R6 / R9: disable, priority, resume, re-arm
    run_cyc(0, 20, 25, 64, 1'b1, 1'b0, wa, wb);
    check("R6 disable at primary edge", wa, 0);
    run_cyc(1, 20, 18, 64, 1'b0, 1'b0, wa, wb);
    check("R6 B stays disabled", wb, 0);
    run_cyc(0, 20, 25, 64, 1'b1, 1'b1, wa, wb);
    check("R6 disable wins over resume", wa, 0);
    idle(4, 1'b1);
    run_cyc(0, 20, 25, 64, 1'b0, 1'b0, wa, wb);
    check("R9 first A cycle after resume", wa, 0);
    run_cyc(1, 20, 18, 64, 1'b0, 1'b0, wa, wb);
    check("R9 first B cycle after resume", wb, 0);
    run_cyc(0, 20, 25, 64, 1'b0, 1'b0, wa, wb);
    check("R9 A drives in second cycle", wa, 23);
    run_cyc(1, 20, 18, 64, 1'b0, 1'b0, wa, wb);
    check("R9 B drives in second cycle", wb, 16);

    // R10: window two of A still open when B starts
    dt_cfg = '0;
    run_cyc(0, 10, 40, 64, 1'b0, 1'b0, wa, wb);
    check("R3 A extension 5 with primary 10", wa, 15);
    run_cyc(1, 20, 20, 64, 1'b0, 1'b0, wa, wb);
    check("R1 B before clash", wb, 18);
    run_cyc(0, 10, 40, 12, 1'b0, 1'b0, wa, wb);
    check("R10 A before B edge", wa, 10);
    run_cyc(1, 20, 20, 64, 1'b0, 1'b0, wa, wb);
    check("R10 B masked in overlap", wb, 0);
    check("R10 A outside overlap", wa, 10);
    check("R10 periods with both high", both_hi, 0);

    // R8: saturation after a fresh reset
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R11 gates low in second reset", int'(sr_gate_a | sr_gate_b), 0);
    @(negedge clk); rst_n = 1'b1;
    dt_cfg = DT_W'(1);
    run_cyc(0, 1100, 1100, 1130, 1'b0, 1'b0, wa, wb);
    check("R9 first long cycle", wa, 0);
    run_cyc(0, 1100, 1100, 1130, 1'b0, 1'b0, wa, wb);
    check("R8 conduction count saturates at 1023", wa, 1021);
    check("R8 B quiet", wb, 0);

    finished = 1'b1;
    report();
  end
endmodule